// File: doc/BRIEF.md
# Eight-Input Priority Interrupt Controller

This block gathers eight interrupt request lines and picks one of them for the processor using fixed priority, where input 0 ranks highest. The processor talks to it through two byte-wide ports. The command port takes initialization and operation commands. The data port holds the mask. A byte written to the command port with bit 4 set starts an initialization sequence. The data-port writes that follow are then taken as a vector base, an optional cascade word and an optional mode word. Once that sequence is complete, data-port writes load the mask.

An edge on an input sets a pending bit. The controller raises its interrupt output when a pending, unmasked input outranks every input already in service. The processor answers with a one-cycle acknowledge. The controller replies on the next cycle with an 8-bit vector and a valid strobe. It also moves the winning input from pending to in-service, unless automatic end-of-interrupt is on. Software closes an interrupt with one of two commands: a specific end-of-interrupt that names the level, or a non-specific one that retires the highest-ranked level in service. A command-port read returns either the pending register or the in-service register, chosen by a sticky command. For cascaded systems the cascade flag is brought out, together with either the master's slave map or the slave's own identity.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the mask reads 0xFF on the data port, `irqOut` and `vecValid` are low, and a command-port read returns the pending register, which is 0x00.
- R2: A command write with bit 4 set starts initialization. It clears the mask, in-service and pending registers and resets the readback selection to pending. Bit 1 clear means cascaded, so a cascade word is expected. Bit 0 set means a mode word is expected. The following data writes are taken in order: vector base, then cascade word (if cascaded), then mode word (if requested). `irqOut` stays low until the sequence is complete.
- R3: Data-port writes that arrive while initialization is incomplete never change the mask.
- R4: The vector for input n is the vector base plus n (modulo 256). `cascadeOn` is high when the initialization command had bit 1 clear. `cascadeCfg` holds the whole cascade word when `slaveRole` is 0, and only its low 3 bits (the master input number) when `slaveRole` is 1.
- R5: A pending bit is set on a rising edge of its input. It drops if the input goes low before acknowledge, and it is cleared when that input is acknowledged.
- R6: Once initialization is complete, data-port writes load the mask and data-port reads return it. Mask bit n set keeps input n from raising `irqOut`.
- R7: Priority is fixed, with input 0 highest. `irqOut` is high only while some pending, unmasked input has a lower index than every in-service bit. An acknowledge serves the lowest such index.
- R8: A one-cycle `ackReq` produces, on the next clock edge, `vecValid` high for one cycle with the vector. In normal mode it also clears that input's pending bit and sets its in-service bit.
- R9: If no input is eligible when `ackReq` is sampled, the vector is base plus 7 and no in-service bit changes. This holds even when input 7 is masked.
- R10: When bit 1 of the mode word is set (automatic end-of-interrupt), an acknowledge sets no in-service bit.
- R11: The command 0x60+n (specific end-of-interrupt) clears in-service bit n and no other bit.
- R12: The command 0x20 (non-specific end-of-interrupt) clears the lowest-index set in-service bit.
- R13: The command 0x0A selects the pending register for command-port reads, and 0x0B selects the in-service register. The selection holds until it is changed again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrStb | input | 1 | Register write strobe |
| addrIsData | input | 1 | Port select: 0 command port, 1 data port |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data of the selected port |
| slaveRole | input | 1 | 1 when this controller sits as a slave |
| irqIn | input | 8 | Interrupt request inputs |
| ackReq | input | 1 | One-cycle acknowledge from the processor |
| irqOut | output | 1 | Interrupt request to the processor |
| vecValid | output | 1 | Vector valid strobe |
| vecOut | output | 8 | Delivered vector |
| cascadeOn | output | 1 | Cascaded configuration flag |
| cascadeCfg | output | 8 | Slave map (master) or identity (slave) |

## Verification
Some internal faults show up on the very next read. A corrupted in-service bit appears in the in-service readback and in `irqOut` within one cycle, because the nesting gate is combinational. A lost or stale pending bit likewise shows in the pending readback and in `irqOut` right away. Other faults only show up one cycle after the next acknowledge, through a wrong vector or a missing spurious vector: a mis-tracked init step, which puts the vector base or the mask in the wrong place, and a wrong priority choice. End-of-interrupt faults are found by reading the in-service register straight after each command, with two levels in service at once.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  localparam int unsigned NUM_IN = 8;
  localparam int unsigned IDX_W  = $clog2(NUM_IN);
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [1:0] {
    ST_READY,
    ST_BASE,
    ST_CASC,
    ST_MODE
  } initState_t;

  typedef struct packed {
    logic             imrLoad;
    logic             initClear;
    logic             eoiAny;
    logic             eoiSpecific;
    logic [IDX_W-1:0] eoiLevel;
  } ctrlStrobes_t;
endpackage

// File: rtl/prio_irq_ctrl_fsm.sv
module prio_irq_ctrl_fsm
  import prio_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrStb,
  input  logic              addrIsData,
  input  logic [BYTE_W-1:0] wrData,
  input  logic              slaveRole,
  output ctrlStrobes_t      strobes,
  output logic [BYTE_W-1:0] vecBase,
  output logic              aeoiOn,
  output logic              readIsr,
  output logic              cascadeOn,
  output logic [BYTE_W-1:0] cascadeCfg,
  output logic              configured
);
  initState_t state;
  logic needMode;
  logic cmdWr, dataWr, isInit, isOcw2, isOcw3;

  assign cmdWr  = wrStb && !addrIsData;
  assign dataWr = wrStb && addrIsData;
  assign isInit = cmdWr && wrData[4];
  assign isOcw2 = cmdWr && !wrData[4] && !wrData[3];
  assign isOcw3 = cmdWr && !wrData[4] && wrData[3];
  assign configured = (state == ST_READY);

  always_comb begin
    strobes.initClear   = isInit;
    strobes.imrLoad     = dataWr && (state == ST_READY);
    // 001 = non-specific, 011 = specific end-of-interrupt
    strobes.eoiAny      = isOcw2 && wrData[5] && !wrData[7];
    strobes.eoiSpecific = wrData[6];
    strobes.eoiLevel    = wrData[IDX_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_READY;
      needMode   <= 1'b0;
      vecBase    <= '0;
      aeoiOn     <= 1'b0;
      readIsr    <= 1'b0;
      cascadeOn  <= 1'b0;
      cascadeCfg <= '0;
    end else if (isInit) begin
      state     <= ST_BASE;
      needMode  <= wrData[0];
      cascadeOn <= !wrData[1];
      readIsr   <= 1'b0;
      aeoiOn    <= 1'b0;
    end else if (isOcw3) begin
      if (wrData[1]) readIsr <= wrData[0];
    end else if (dataWr) begin
      case (state)
        ST_BASE: begin
          vecBase <= wrData;
          if (cascadeOn)     state <= ST_CASC;
          else if (needMode) state <= ST_MODE;
          else               state <= ST_READY;
        end
        ST_CASC: begin
          cascadeCfg <= slaveRole ? {{(BYTE_W-3){1'b0}}, wrData[2:0]} : wrData;
          state      <= needMode ? ST_MODE : ST_READY;
        end
        ST_MODE: begin
          aeoiOn <= wrData[1];
          state  <= ST_READY;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/prio_irq_ctrl_dp.sv
module prio_irq_ctrl_dp
  import prio_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_IN-1:0] irqIn,
  input  logic              ackReq,
  input  ctrlStrobes_t      strobes,
  input  logic [BYTE_W-1:0] wrData,
  input  logic [BYTE_W-1:0] vecBase,
  input  logic              aeoiOn,
  input  logic              configured,
  output logic [NUM_IN-1:0] irrVec,
  output logic [NUM_IN-1:0] isrVec,
  output logic [NUM_IN-1:0] imrVec,
  output logic              irqOut,
  output logic              vecValid,
  output logic [BYTE_W-1:0] vecOut
);
  localparam logic [IDX_W-1:0]  SPUR_IDX = IDX_W'(NUM_IN - 1);
  localparam logic [NUM_IN-1:0] ONE_BIT  = NUM_IN'(1);

  logic [NUM_IN-1:0] irqPrev, blockMask, candVec;
  logic [NUM_IN-1:0] ackClr, isrSet, eoiClr;
  logic              winFound, isrLowFound, acc;
  logic [IDX_W-1:0]  winIdx, isrLowIdx, vecIdx;

  always_comb begin
    acc = 1'b0;
    for (int n = 0; n < NUM_IN; n++) begin
      acc          = acc | isrVec[n];
      blockMask[n] = acc;
    end
    candVec = irrVec & ~imrVec & ~blockMask;
  end

  always_comb begin
    winFound = 1'b0;
    winIdx   = '0;
    isrLowFound = 1'b0;
    isrLowIdx   = '0;
    for (int n = NUM_IN - 1; n >= 0; n--) begin
      if (candVec[n]) begin
        winFound = 1'b1;
        winIdx   = IDX_W'(n);
      end
      if (isrVec[n]) begin
        isrLowFound = 1'b1;
        isrLowIdx   = IDX_W'(n);
      end
    end
  end

  assign irqOut = configured && winFound;
  assign vecIdx = winFound ? winIdx : SPUR_IDX;
  assign ackClr = (ackReq && winFound) ? (ONE_BIT << winIdx) : '0;
  assign isrSet = aeoiOn ? '0 : ackClr;

  always_comb begin
    eoiClr = '0;
    if (strobes.eoiAny) begin
      if (strobes.eoiSpecific)  eoiClr = ONE_BIT << strobes.eoiLevel;
      else if (isrLowFound)     eoiClr = ONE_BIT << isrLowIdx;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqPrev  <= '0;
      irrVec   <= '0;
      isrVec   <= '0;
      imrVec   <= '1;
      vecValid <= 1'b0;
      vecOut   <= '0;
    end else begin
      irqPrev  <= irqIn;
      vecValid <= ackReq;
      if (ackReq) vecOut <= vecBase + BYTE_W'(vecIdx);
      if (strobes.initClear) begin
        irrVec <= '0;
        isrVec <= '0;
        imrVec <= '0;
      end else begin
        irrVec <= (irrVec | (irqIn & ~irqPrev)) & irqIn & ~ackClr;
        isrVec <= (isrVec & ~eoiClr) | isrSet;
        if (strobes.imrLoad) imrVec <= wrData[NUM_IN-1:0];
      end
    end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrStb,
  input  logic       addrIsData,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  input  logic       slaveRole,
  input  logic [7:0] irqIn,
  input  logic       ackReq,
  output logic       irqOut,
  output logic       vecValid,
  output logic [7:0] vecOut,
  output logic       cascadeOn,
  output logic [7:0] cascadeCfg
);
  ctrlStrobes_t      strobes;
  logic [BYTE_W-1:0] vecBase;
  logic              aeoiOn, readIsr, configured;
  logic [NUM_IN-1:0] irrVec, isrVec, imrVec;

  prio_irq_ctrl_fsm u_fsm (
    .clk(clk), .rstN(rstN), .wrStb(wrStb), .addrIsData(addrIsData),
    .wrData(wrData), .slaveRole(slaveRole), .strobes(strobes),
    .vecBase(vecBase), .aeoiOn(aeoiOn), .readIsr(readIsr),
    .cascadeOn(cascadeOn), .cascadeCfg(cascadeCfg), .configured(configured)
  );

  prio_irq_ctrl_dp u_dp (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .ackReq(ackReq),
    .strobes(strobes), .wrData(wrData), .vecBase(vecBase),
    .aeoiOn(aeoiOn), .configured(configured), .irrVec(irrVec),
    .isrVec(isrVec), .imrVec(imrVec), .irqOut(irqOut),
    .vecValid(vecValid), .vecOut(vecOut)
  );

  assign rdData = addrIsData ? imrVec : (readIsr ? isrVec : irrVec);
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk (
  input logic       clk,
  input logic       rstN,
  input logic       wrStb,
  input logic       addrIsData,
  input logic       ackReq,
  input logic       irqOut,
  input logic       vecValid,
  input logic       configured,
  input logic [7:0] irrVec,
  input logic [7:0] isrVec,
  input logic [7:0] imrVec
);
  p_quiet_in_init_r2: assert property (@(posedge clk) disable iff (!rstN)
    !configured |-> !irqOut);

  p_init_keeps_mask_r3: assert property (@(posedge clk) disable iff (!rstN)
    (wrStb && addrIsData && !configured) |=> $stable(imrVec));

  p_masked_silent_r6: assert property (@(posedge clk) disable iff (!rstN)
    ((irrVec & ~imrVec) == 8'h00) |-> !irqOut);

  p_single_service_r7: assert property (@(posedge clk) disable iff (!rstN)
    $countones(isrVec & ~$past(isrVec)) <= 1);

  p_vector_after_ack_r8: assert property (@(posedge clk) disable iff (!rstN)
    vecValid |-> $past(ackReq));

  p_service_needs_ack_r8: assert property (@(posedge clk) disable iff (!rstN)
    ((isrVec & ~$past(isrVec)) != 8'h00) |-> $past(ackReq));
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk u_chk (
  .clk(clk), .rstN(rstN), .wrStb(wrStb), .addrIsData(addrIsData),
  .ackReq(ackReq), .irqOut(irqOut), .vecValid(vecValid),
  .configured(configured), .irrVec(irrVec), .isrVec(isrVec), .imrVec(imrVec)
);

// File: tb/prio_irq_ctrl_test.sv
module prio_irq_ctrl_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrStb = 1'b0;
  logic       addrIsData = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;
  logic       slaveRole = 1'b0;
  logic [7:0] irqIn = 8'h00;
  logic       ackReq = 1'b0;
  logic       irqOut, vecValid, cascadeOn;
  logic [7:0] vecOut, cascadeCfg;
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  prio_irq_ctrl uut (
    .clk(clk), .rstN(rstN), .wrStb(wrStb), .addrIsData(addrIsData),
    .wrData(wrData), .rdData(rdData), .slaveRole(slaveRole), .irqIn(irqIn),
    .ackReq(ackReq), .irqOut(irqOut), .vecValid(vecValid), .vecOut(vecOut),
    .cascadeOn(cascadeOn), .cascadeCfg(cascadeCfg)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic isData, input logic [7:0] val);
    @(negedge clk);
    addrIsData = isData;
    wrData     = val;
    wrStb      = 1'b1;
    @(negedge clk);
    wrStb = 1'b0;
  endtask

  task automatic rd(input logic isData, output logic [7:0] val);
    addrIsData = isData;
    #1;
    val = rdData;
  endtask

  task automatic setIrq(input logic [7:0] v);
    @(negedge clk);
    irqIn = v;
    @(negedge clk);
  endtask

  task automatic ack(input string tag, input logic [7:0] expVec);
    @(negedge clk);
    ackReq = 1'b1;
    @(negedge clk);
    ackReq = 1'b0;
    check({tag, " vecValid"}, {7'd0, vecValid}, 8'h01);
    check({tag, " vector"}, vecOut, expVec);
    @(negedge clk);
    check({tag, " strobe one cycle"}, {7'd0, vecValid}, 8'h00);
  endtask

  task automatic testReset();
    logic [7:0] v;
    rd(1'b1, v);
    check("R1 mask after reset", v, 8'hFF);
    rd(1'b0, v);
    check("R1 pending readback", v, 8'h00);
    check("R1 irqOut", {7'd0, irqOut}, 8'h00);
    check("R1 vecValid", {7'd0, vecValid}, 8'h00);
  endtask

  task automatic testInitMaster();
    logic [7:0] v;
    wr(1'b0, 8'h11);
    wr(1'b1, 8'h20);
    rd(1'b1, v);
    check("R3 mask untouched by base word", v, 8'h00);
    wr(1'b1, 8'h04);
    rd(1'b1, v);
    check("R3 mask untouched by cascade word", v, 8'h00);
    wr(1'b1, 8'h01);
    rd(1'b1, v);
    check("R2 mask cleared by init", v, 8'h00);
    check("R4 cascade flag", {7'd0, cascadeOn}, 8'h01);
    check("R4 master slave map", cascadeCfg, 8'h04);
  endtask

  task automatic testMaskAndAck();
    logic [7:0] v;
    wr(1'b1, 8'hFF);
    setIrq(8'h08);
    check("R6 masked input silent", {7'd0, irqOut}, 8'h00);
    rd(1'b0, v);
    check("R5 pending set on edge", v, 8'h08);
    wr(1'b1, 8'hF7);
    rd(1'b1, v);
    check("R6 mask readback", v, 8'hF7);
    check("R6 unmasked raises irqOut", {7'd0, irqOut}, 8'h01);
    ack("R8 ack input 3", 8'h23);
    wr(1'b0, 8'h0B);
    rd(1'b0, v);
    check("R8 in-service set", v, 8'h08);
    rd(1'b0, v);
    check("R13 selection persists", v, 8'h08);
    wr(1'b0, 8'h0A);
    rd(1'b0, v);
    check("R5 pending cleared by ack", v, 8'h00);
    check("R8 irqOut low after ack", {7'd0, irqOut}, 8'h00);
  endtask

  task automatic testNestingAndEoi();
    logic [7:0] v;
    wr(1'b1, 8'h00);
    setIrq(8'h28);
    check("R7 lower level blocked by service", {7'd0, irqOut}, 8'h00);
    setIrq(8'h2A);
    check("R7 higher level preempts", {7'd0, irqOut}, 8'h01);
    ack("R7 ack picks input 1", 8'h21);
    wr(1'b0, 8'h0B);
    rd(1'b0, v);
    check("R7 two levels in service", v, 8'h0A);
    wr(1'b0, 8'h63);
    rd(1'b0, v);
    check("R11 specific clears only bit 3", v, 8'h02);
    check("R7 input 5 still blocked", {7'd0, irqOut}, 8'h00);
    wr(1'b0, 8'h20);
    rd(1'b0, v);
    check("R12 non-specific clears lowest", v, 8'h00);
    check("R7 input 5 now requests", {7'd0, irqOut}, 8'h01);
    ack("R7 ack input 5", 8'h25);
    rd(1'b0, v);
    check("R8 in-service bit 5", v, 8'h20);
    wr(1'b0, 8'h20);
    rd(1'b0, v);
    check("R12 non-specific clears bit 5", v, 8'h00);
  endtask

  task automatic testDropAndSpurious();
    logic [7:0] v;
    setIrq(8'h00);
    wr(1'b0, 8'h0A);
    setIrq(8'h10);
    check("R5 request raises irqOut", {7'd0, irqOut}, 8'h01);
    setIrq(8'h00);
    check("R5 dropped request lowers irqOut", {7'd0, irqOut}, 8'h00);
    rd(1'b0, v);
    check("R5 dropped pending bit", v, 8'h00);
    wr(1'b1, 8'hFF);
    ack("R9 spurious vector", 8'h27);
    wr(1'b0, 8'h0B);
    rd(1'b0, v);
    check("R9 no in-service change", v, 8'h00);
  endtask

  task automatic testAutoEoi();
    logic [7:0] v;
    wr(1'b0, 8'h13);
    wr(1'b1, 8'h48);
    setIrq(8'h40);
    check("R2 irqOut held during init", {7'd0, irqOut}, 8'h00);
    wr(1'b1, 8'h02);
    check("R4 single mode flag", {7'd0, cascadeOn}, 8'h00);
    check("R2 irqOut after init", {7'd0, irqOut}, 8'h01);
    ack("R4 vector base 0x48", 8'h4E);
    rd(1'b0, v);
    check("R2 readback reset to pending", v, 8'h00);
    wr(1'b0, 8'h0B);
    rd(1'b0, v);
    check("R10 auto EOI leaves no service", v, 8'h00);
    check("R10 irqOut low", {7'd0, irqOut}, 8'h00);
  endtask

  task automatic testSlave();
    logic [7:0] v;
    setIrq(8'h00);
    slaveRole = 1'b1;
    wr(1'b0, 8'h11);
    wr(1'b1, 8'h70);
    wr(1'b1, 8'hFA);
    wr(1'b1, 8'h01);
    check("R4 slave cascade flag", {7'd0, cascadeOn}, 8'h01);
    check("R4 slave identity", cascadeCfg, 8'h02);
    setIrq(8'h01);
    ack("R4 slave vector", 8'h70);
    wr(1'b0, 8'h0B);
    rd(1'b0, v);
    check("R8 normal mode service bit", v, 8'h01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testInitMaster();
    testMaskAndAck();
    testNestingAndEoi();
    testDropAndSpurious();
    testAutoEoi();
    testSlave();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule